// File: doc/BRIEF.md
# Driver Impedance Code Search Sequencer

This block finds the pull-up and pull-down strength codes of a memory output driver. It applies trial codes to an external impedance comparator, which returns one result bit, and it steps through the codes until that bit changes. The pull-up code is searched first, with the pull-down code held at zero. The pull-down code is searched next, with the pull-up code fixed at the value just found. For every trial the block drives each code and that code plus one. It enables the comparator for a settle window of fixed length and then samples the resynchronised result. The comparator is switched off before the next code is applied.

When both searches are over, the block commits the two codes to the driver. This takes two load and clear handshakes, the pull-up side first and the pull-down side second. It then raises `done` and holds the final codes until it is started again. One pulse on `start` runs the whole sequence with no further attention.

Top module: `zq_code_search`

## Requirements
- R1: After reset, `done`, `cmp_en`, `load_pulse`, `clear_pulse` and `pd_sel` are 0, and all code and result outputs are 0.
- R2: The pull-up search tries codes 0, 1, 2 and so on in order, with `pd_sel`=0 and `pd_code`=0. It stops at the first code for which the comparator reports 1. The pull-up result is that code, or 31 if no code up to 31 reports 1.
- R3: During each trial, the codes, the plus-one codes (`pu_code_p1`=`pu_code`+1 and `pd_code_p1`=`pd_code`+1) and `pd_sel` stay steady while `cmp_en` is high. `cmp_en` stays high for at least SETTLE_CYC cycles, where SETTLE_CYC = ceil(SETTLE_NS·CLK_MHZ/1000)+1, which is 61 by default. `cmp_en` drops for at least one cycle between trials. The comparator bit passes through two flops before it is sampled.
- R4: The pull-down search runs with `pd_sel`=1 and with `pu_code` held at the pull-up result. It tries pull-down codes 0, 1, 2 and so on in order and stops at the first code of 1 or more for which the comparator reports 0. A 0 reported at code 0 does not stop the search.
- R5: If the pull-down search stops at code k, the pull-down result is k−1. If no code from 1 to 14 reports 0, the search ends after code 14 and the result is 13. `pd_code` never exceeds 14.
- R6: The commit works as follows. One `load_pulse` cycle, with `cmp_en` high, `pd_sel`=0 and the final codes (plus-one values alongside) on the code outputs. Then one `clear_pulse` cycle. Then the same pair of cycles again with `pd_sel`=1. Exactly two loads and two clears occur in each run.
- R7: `done` rises after the second clear and stays high until the next accepted `start`. While `done` is high, `pu_result` and `pd_result` hold the final codes and are stable.
- R8: A `start` pulse that arrives while a search or commit is in progress has no effect on the trials, the results or the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run (taken only when idle or done) |
| cmp_result | input | 1 | Asynchronous comparator result bit |
| pu_code | output | PU_W | Pull-up code applied to the driver |
| pd_code | output | PD_W | Pull-down code applied to the driver |
| pu_code_p1 | output | PU_W+1 | Pull-up code plus one |
| pd_code_p1 | output | PD_W+1 | Pull-down code plus one |
| pd_sel | output | 1 | 0 selects the pull-up side, 1 selects the pull-down side |
| cmp_en | output | 1 | Comparator enable |
| load_pulse | output | 1 | One-cycle strobe that loads the codes into the driver |
| clear_pulse | output | 1 | One-cycle strobe that clears the load path |
| done | output | 1 | Run complete; results are valid |
| pu_result | output | PU_W | Final pull-up code |
| pd_result | output | PD_W | Final pull-down code |

## Verification
The assertions assume that the comparator bit depends only on the codes and the select applied at that moment. They also assume that it settles well inside the enable window, so that its value two flops later belongs to the current trial. The bench models the comparator as a pure threshold on the applied code. It compares against `pu_code` on the pull-up side and against `pd_code` on the pull-down side, so the bit changes only when the block changes a code. It uses a short settle window, which still exceeds the two synchroniser stages. Every pull-up threshold from 0 to 32 and every pull-down threshold from 0 to 16 is run, along with repeated `start` pulses inside a run.

// File: rtl/zqs_pkg.sv
// Shared types of the impedance code search sequencer.
package zqs_pkg;

    // Sequencer states: two sweeps (each a try/decide pair), then a two-sided commit
    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_PU_TRY  = 4'd1,
        ST_PU_NEXT = 4'd2,
        ST_PD_TRY  = 4'd3,
        ST_PD_NEXT = 4'd4,
        ST_LD_PU   = 4'd5,
        ST_CL_PU   = 4'd6,
        ST_LD_PD   = 4'd7,
        ST_CL_PD   = 4'd8,
        ST_FIN     = 4'd9
    } zqs_state_e;

endpackage

// File: rtl/zqs_sync.sv
// Multi-flop synchroniser for a single asynchronous bit.
// Assumes: the input is level-like and is held far longer than STAGES cycles.
module zqs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous bit through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/zqs_settle_timer.sv
// Counts cycles while the comparator is enabled and flags the last cycle of
// the settle window. The count restarts whenever run drops.
// Assumes: CYC >= 3, so the two-flop synchroniser has caught up before sampling.
module zqs_settle_timer #(
    parameter int CYC = 61
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    // Free-run while enabled, hold at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST_CNT) cnt <= cnt + 1'b1;
    end

    assign last = run && (cnt == LAST_CNT);
endmodule

// File: rtl/zqs_ctrl.sv
// Search and commit controller. It sweeps the pull-up code upward until the
// comparator reads 1, then the pull-down code upward until it reads 0 (taken
// only after at least one step). It backs the pull-down result off by one and
// commits both codes with load/clear pairs.
// Assumes: cmp_sync is already resynchronised; win_last marks the last cycle
// of a settle window.
module zqs_ctrl
    import zqs_pkg::*;
#(
    parameter int PU_W = 5,
    parameter int PD_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cmp_sync,
    input  logic            win_last,
    output logic            settle_run,
    output logic [PU_W-1:0] pu_code,
    output logic [PD_W-1:0] pd_code,
    output logic            pd_sel,
    output logic            cmp_en,
    output logic            load_pulse,
    output logic            clear_pulse,
    output logic            done,
    output logic [PU_W-1:0] pu_result,
    output logic [PD_W-1:0] pd_result
);
    localparam logic [PU_W-1:0] PU_LAST = {PU_W{1'b1}};
    localparam logic [PD_W-1:0] PD_LAST = {{(PD_W-1){1'b1}}, 1'b0};
    localparam logic [PD_W-1:0] PD_CAP  = PD_LAST - 1'b1;

    zqs_state_e      state;
    logic            res_q;
    logic [PU_W-1:0] pu_q;
    logic [PD_W-1:0] pd_q;
    logic            sel_q;
    logic            done_q;
    logic [PU_W-1:0] pu_res_q;
    logic [PD_W-1:0] pd_res_q;
    logic            accept;

    assign accept = start && (state == ST_IDLE || state == ST_FIN);

    // Sequencer: trial codes, stop decisions, commit steps and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            res_q    <= 1'b0;
            pu_q     <= '0;
            pd_q     <= '0;
            sel_q    <= 1'b0;
            done_q   <= 1'b0;
            pu_res_q <= '0;
            pd_res_q <= '0;
        end else if (accept) begin
            state    <= ST_PU_TRY;
            pu_q     <= '0;
            pd_q     <= '0;
            sel_q    <= 1'b0;
            done_q   <= 1'b0;
            pu_res_q <= '0;
            pd_res_q <= '0;
        end else begin
            unique case (state)
                ST_PU_TRY, ST_PD_TRY: begin
                    if (win_last) begin
                        res_q <= cmp_sync;
                        state <= (state == ST_PU_TRY) ? ST_PU_NEXT : ST_PD_NEXT;
                    end
                end
                ST_PU_NEXT: begin
                    if (res_q || pu_q == PU_LAST) begin
                        pu_res_q <= pu_q;
                        pd_q     <= '0;
                        sel_q    <= 1'b1;
                        state    <= ST_PD_TRY;
                    end else begin
                        pu_q  <= pu_q + 1'b1;
                        state <= ST_PU_TRY;
                    end
                end
                ST_PD_NEXT: begin
                    if (!res_q && pd_q != '0) begin
                        pd_res_q <= pd_q - 1'b1;
                        pd_q     <= pd_q - 1'b1;
                        sel_q    <= 1'b0;
                        state    <= ST_LD_PU;
                    end else if (pd_q == PD_LAST) begin
                        pd_res_q <= PD_CAP;
                        pd_q     <= PD_CAP;
                        sel_q    <= 1'b0;
                        state    <= ST_LD_PU;
                    end else begin
                        pd_q  <= pd_q + 1'b1;
                        state <= ST_PD_TRY;
                    end
                end
                ST_LD_PU: state <= ST_CL_PU;
                ST_CL_PU: begin
                    sel_q <= 1'b1;
                    state <= ST_LD_PD;
                end
                ST_LD_PD: state <= ST_CL_PD;
                ST_CL_PD: begin
                    done_q <= 1'b1;
                    state  <= ST_FIN;
                end
                default: state <= state;
            endcase
        end
    end

    // Strobes decoded from the state register
    always_comb begin
        settle_run  = (state == ST_PU_TRY) || (state == ST_PD_TRY);
        load_pulse  = (state == ST_LD_PU) || (state == ST_LD_PD);
        clear_pulse = (state == ST_CL_PU) || (state == ST_CL_PD);
        cmp_en      = settle_run || load_pulse;
    end

    assign pu_code   = pu_q;
    assign pd_code   = pd_q;
    assign pd_sel    = sel_q;
    assign done      = done_q;
    assign pu_result = pu_res_q;
    assign pd_result = pd_res_q;
endmodule

// File: rtl/zq_code_search.sv
// Top of the driver impedance code search sequencer. Joins the comparator
// synchroniser, the settle-window timer and the search/commit controller, and
// forms the plus-one code outputs.
// Assumes: CLK_MHZ and SETTLE_NS describe the real clock and comparator settle time.
module zq_code_search #(
    parameter int PU_W      = 5,
    parameter int PD_W      = 4,
    parameter int CLK_MHZ   = 200,
    parameter int SETTLE_NS = 300,
    parameter int SYNC_STG  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cmp_result,
    output logic [PU_W-1:0] pu_code,
    output logic [PD_W-1:0] pd_code,
    output logic [PU_W:0]   pu_code_p1,
    output logic [PD_W:0]   pd_code_p1,
    output logic            pd_sel,
    output logic            cmp_en,
    output logic            load_pulse,
    output logic            clear_pulse,
    output logic            done,
    output logic [PU_W-1:0] pu_result,
    output logic [PD_W-1:0] pd_result
);
    localparam int SETTLE_CYC = (SETTLE_NS * CLK_MHZ + 999) / 1000 + 1;

    logic cmp_sync;
    logic win_last;
    logic settle_run;

    zqs_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_result),
        .q_sync  (cmp_sync)
    );

    zqs_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .last  (win_last)
    );

    zqs_ctrl #(.PU_W(PU_W), .PD_W(PD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmp_sync    (cmp_sync),
        .win_last    (win_last),
        .settle_run  (settle_run),
        .pu_code     (pu_code),
        .pd_code     (pd_code),
        .pd_sel      (pd_sel),
        .cmp_en      (cmp_en),
        .load_pulse  (load_pulse),
        .clear_pulse (clear_pulse),
        .done        (done),
        .pu_result   (pu_result),
        .pd_result   (pd_result)
    );

    // Plus-one companions of the applied codes
    assign pu_code_p1 = {1'b0, pu_code} + 1'b1;
    assign pd_code_p1 = {1'b0, pd_code} + 1'b1;
endmodule

// File: rtl/zq_code_search_chk.sv
// Property checker for zq_code_search, attached by bind.
// Assumes: the comparator input settles within the enable window.
module zq_code_search_chk #(
    parameter int PU_W      = 5,
    parameter int PD_W      = 4,
    parameter int CLK_MHZ   = 200,
    parameter int SETTLE_NS = 300
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [PU_W-1:0] pu_code,
    input logic [PD_W-1:0] pd_code,
    input logic            pd_sel,
    input logic            cmp_en,
    input logic            load_pulse,
    input logic            clear_pulse,
    input logic            done,
    input logic [PU_W-1:0] pu_result,
    input logic [PD_W-1:0] pd_result
);
    localparam int SETTLE_CYC = (SETTLE_NS * CLK_MHZ + 999) / 1000 + 1;
    localparam int RW = $clog2(SETTLE_CYC + 2) + 1;
    localparam logic [PD_W-1:0] PD_TOP = {{(PD_W-1){1'b1}}, 1'b0};

    logic [RW-1:0] en_run;

    // Length of the current comparator-enable stretch outside commit loads
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_run <= '0;
        else if (cmp_en && !load_pulse) begin
            if (en_run != {RW{1'b1}}) en_run <= en_run + 1'b1;
        end else                          en_run <= '0;
    end

    p_codes_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en && $past(cmp_en) && !load_pulse |->
            $stable(pu_code) && $stable(pd_code) && $stable(pd_sel));

    p_settle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_en) && !$past(load_pulse) |-> en_run >= RW'(SETTLE_CYC));

    p_pu_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en && !pd_sel && !load_pulse |-> pd_code == '0);

    p_pd_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd_code <= PD_TOP);

    p_load_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> cmp_en);

    p_clear_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> clear_pulse && !cmp_en);

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(pu_result) && $stable(pd_result));

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmp_en && !load_pulse && !clear_pulse);
endmodule

bind zq_code_search zq_code_search_chk #(
    .PU_W(PU_W), .PD_W(PD_W), .CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pu_code     (pu_code),
    .pd_code     (pd_code),
    .pd_sel      (pd_sel),
    .cmp_en      (cmp_en),
    .load_pulse  (load_pulse),
    .clear_pulse (clear_pulse),
    .done        (done),
    .pu_result   (pu_result),
    .pd_result   (pd_result)
);

// File: tb/zq_code_search_tb.sv
module zq_code_search_tb;
    localparam int PU_W = 5;
    localparam int PD_W = 4;
    localparam int CLK_MHZ = 200;
    localparam int SETTLE_NS = 20;
    localparam int SETTLE_EXP = (SETTLE_NS * CLK_MHZ + 999) / 1000 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_result;
    logic [PU_W-1:0] pu_code;
    logic [PD_W-1:0] pd_code;
    logic [PU_W:0] pu_code_p1;
    logic [PD_W:0] pd_code_p1;
    logic pd_sel, cmp_en, load_pulse, clear_pulse, done;
    logic [PU_W-1:0] pu_result;
    logic [PD_W-1:0] pd_result;

    int pu_thr = 40;
    int pd_thr = 40;
    int exp_pu = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit timed_out = 1'b0;

    always #2.5 clk = ~clk;

    zq_code_search #(.PU_W(PU_W), .PD_W(PD_W), .CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_result(cmp_result),
        .pu_code(pu_code), .pd_code(pd_code), .pu_code_p1(pu_code_p1), .pd_code_p1(pd_code_p1),
        .pd_sel(pd_sel), .cmp_en(cmp_en), .load_pulse(load_pulse), .clear_pulse(clear_pulse),
        .done(done), .pu_result(pu_result), .pd_result(pd_result)
    );

    // Comparator model: threshold on the code of the selected side
    always_comb begin
        if (pd_sel) cmp_result = (int'(pd_code) < pd_thr);
        else        cmp_result = (int'(pu_code) >= pu_thr);
    end

    // Cumulative monitor, sampled on the falling edge
    int pu_trials = 0, pd_trials = 0, order_err = 0, p1_err = 0, side_err = 0;
    int short_win = 0, seq_err = 0, n_ld = 0, n_cl = 0, en_len = 0;
    int last_pu = 0, last_pd = 0;
    int ld_sel[2], ld_pu[2], ld_pd[2], ld_pup1[2], ld_pdp1[2], ld_cmp[2];
    logic prev_en = 1'b0, prev_ld = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmp_en && !load_pulse && !prev_en) begin
                if (!pd_sel) begin
                    pu_trials++;
                    if (pu_code != 0 && int'(pu_code) != last_pu + 1) order_err++;
                    if (pd_code != 0) side_err++;
                    last_pu = int'(pu_code);
                end else begin
                    pd_trials++;
                    if (pd_code != 0 && int'(pd_code) != last_pd + 1) order_err++;
                    if (int'(pu_code) != exp_pu) side_err++;
                    last_pd = int'(pd_code);
                end
            end
            if (int'(pu_code_p1) != int'(pu_code) + 1 || int'(pd_code_p1) != int'(pd_code) + 1) p1_err++;
            if (cmp_en && !load_pulse) en_len++;
            else begin
                if (prev_en && !prev_ld && en_len < SETTLE_EXP) short_win++;
                en_len = 0;
            end
            if (prev_ld && !clear_pulse) seq_err++;
            if (load_pulse) begin
                ld_sel[n_ld % 2] = int'(pd_sel);
                ld_pu[n_ld % 2] = int'(pu_code);
                ld_pd[n_ld % 2] = int'(pd_code);
                ld_pup1[n_ld % 2] = int'(pu_code_p1);
                ld_pdp1[n_ld % 2] = int'(pd_code_p1);
                ld_cmp[n_ld % 2] = int'(cmp_en);
                n_ld++;
            end
            if (clear_pulse) n_cl++;
            prev_en = cmp_en;
            prev_ld = load_pulse;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    // One full calibration run against the given thresholds
    task automatic run_case(input int tp, input int td, input bit poke_busy);
        int e_pu, e_pd, e_put, e_pdt;
        int b_put, b_pdt, b_ord, b_p1, b_side, b_short, b_seq, b_ld, b_cl, first;
        e_pu = (tp > 31) ? 31 : tp;
        if (td == 0) begin e_pd = 0; e_pdt = 2; end
        else if (td <= 14) begin e_pd = td - 1; e_pdt = td + 1; end
        else begin e_pd = 13; e_pdt = 15; end
        e_put = e_pu + 1;
        @(negedge clk);
        pu_thr = tp; pd_thr = td; exp_pu = e_pu;
        b_put = pu_trials; b_pdt = pd_trials; b_ord = order_err; b_p1 = p1_err;
        b_side = side_err; b_short = short_win; b_seq = seq_err; b_ld = n_ld; b_cl = n_cl;
        pulse_start();
        if (poke_busy) begin
            repeat (30) @(posedge clk);
            pulse_start();
            repeat (3) @(negedge clk);
            chk(!done, "R8 busy start gave done", int'(done), 0);
        end
        @(negedge clk);
        while (!done) @(negedge clk);
        chk(pu_trials - b_put == e_put, "R2 pull-up trial count", pu_trials - b_put, e_put);
        chk(int'(pu_result) == e_pu, "R2 pull-up result", int'(pu_result), e_pu);
        chk(pd_trials - b_pdt == e_pdt, "R4 pull-down trial count", pd_trials - b_pdt, e_pdt);
        chk(int'(pd_result) == e_pd, "R5 pull-down result", int'(pd_result), e_pd);
        chk(order_err == b_ord && side_err == b_side, "R2 R4 ordering and held side",
            order_err - b_ord + side_err - b_side, 0);
        chk(p1_err == b_p1, "R3 plus-one codes", p1_err - b_p1, 0);
        chk(short_win == b_short, "R3 settle window length", short_win - b_short, 0);
        chk(n_ld - b_ld == 2 && n_cl - b_cl == 2 && seq_err == b_seq, "R6 load/clear count",
            n_ld - b_ld, 2);
        first = b_ld % 2;
        chk(ld_sel[first] == 0 && ld_sel[1-first] == 1, "R6 load select order",
            ld_sel[first] * 2 + ld_sel[1-first], 1);
        for (int i = 0; i < 2; i++) begin
            chk(ld_pu[i] == e_pu && ld_pd[i] == e_pd && ld_pup1[i] == e_pu + 1 &&
                ld_pdp1[i] == e_pd + 1 && ld_cmp[i] == 1, "R6 commit codes",
                ld_pu[i] * 100 + ld_pd[i], e_pu * 100 + e_pd);
        end
        repeat (8) @(negedge clk);
        chk(done && int'(pu_result) == e_pu && int'(pd_result) == e_pd, "R7 done hold",
            int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !cmp_en && !load_pulse && !clear_pulse && !pd_sel, "R1 reset strobes",
            int'({done, cmp_en, load_pulse, clear_pulse, pd_sel}), 0);
        chk(pu_code == 0 && pd_code == 0 && pu_result == 0 && pd_result == 0, "R1 reset codes",
            int'(pu_code) + int'(pd_code) + int'(pu_result) + int'(pd_result), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        for (int t = 0; t <= 32; t++) run_case(t, 5, 1'b0);
        for (int t = 0; t <= 16; t++) run_case(9, t, 1'b0);
        run_case(3, 7, 1'b1);   // R8 busy restart ignored
        run_case(32, 16, 1'b1); // R8 long run, both sweeps exhausted
        run_case(31, 1, 1'b0);
        if (!timed_out) begin
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hang counts as one failed check
    initial begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail + 1);
        $finish;
    end
endmodule